// File: doc/BRIEF.md
# Vectored Interrupt Controller with Nesting

The controller gathers up to 32 interrupt sources and presents one request line, `irq`, to a processor. Software reaches it through a small register window. It enables and disables sources with write-one set and clear commands. It gives each source a trigger mode, a 3-bit priority and a vector word.

When the processor takes the request, it reads the acknowledge register. The controller returns the vector of the winning source, records that source as in service and pushes its priority onto an 8-deep nesting stack. From then on, only a strictly higher priority can raise `irq` again. A write to the end-of-interrupt register pops the stack, and the service of the interrupted source resumes.

Register map (byte addresses on `addr`):

| Address | Access | Purpose |
|---|---|---|
| 0x000 + 4n | write | Mode word of source n |
| 0x080 + 4n | write | Vector word of source n |
| 0x100 | read | Acknowledge |
| 0x104 | read | Status |
| 0x108 | read | Pending |
| 0x10C | read | Enable mask |
| 0x120 | write | Enable-set |
| 0x124 | write | Enable-clear |
| 0x128 | write | Edge-clear |
| 0x130 | write | End-of-interrupt |

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the enable mask at 0x10C reads 0, the pending register at 0x108 reads 0 when all sources are low, the status at 0x104 reads 0 and `irq` is low.
- R2: A write to 0x120 enables each source whose data bit is 1. A write to 0x124 disables each source whose data bit is 1. Data bits that are 0 leave the mask unchanged. The mask reads back at 0x10C.
- R3: In the mode word of source n (0x000+4n), bit 5 set selects edge triggering and bit 5 clear selects level triggering. For a level source, pending bit n at 0x108 follows the input. For an edge source, a rising input edge sets pending bit n, which stays set until it is cleared.
- R4: A write to 0x128 clears the latched edge request of each source whose data bit is 1.
- R5: `irq` is low whenever the bitwise AND of the pending and enable registers is zero.
- R6: Bits 2:0 of the mode word give the priority, and 7 is the highest. Among enabled pending sources the highest priority wins. On a tie, the lower source number wins.
- R7: A read of 0x100 with `irq` high returns the winner's vector word (0x080+4n). Afterwards, the status at 0x104 holds the winner's source number.
- R8: The acknowledge read clears the winner's edge request if the winner is edge-triggered. A level source stays pending while its input is high.
- R9: While a source is in service, `irq` rises only for an enabled pending source of strictly higher priority. Equal or lower priority is held off.
- R10: Any write to 0x130 ends the current service and returns the status to the interrupted source, or to 0 when none is left. With nothing in service, the write has no effect.
- R11: A read of 0x100 with `irq` low returns the default vector 0xFFFFFFFF and changes neither the status nor the in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | 32 | Interrupt source inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the acknowledge side effect) |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as `rd_en` |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that a source input changes at most once per clock, so each edge meets the synchronising register exactly once. The stimulus drives every input at the falling edge and raises only one strobe per operation. Source changes are separate operations, each a full cycle long. This lets the acknowledge, end-of-interrupt and edge-clear effects land on known, separate clock edges.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int          NSRC  = 32,
  parameter int          DW    = 32,
  parameter int          AW    = 12,
  parameter int          DEPTH = 8,
  parameter int          PW    = 3,
  parameter logic [31:0] SPUR  = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] src,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int IW = $clog2(NSRC);
  localparam int KW = $clog2(DEPTH);
  localparam int SW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_ACK = AW'('h100), A_STAT = AW'('h104), A_PEND = AW'('h108),
                            A_MASK = AW'('h10C), A_ESET = AW'('h120), A_ECLR = AW'('h124),
                            A_XCLR = AW'('h128), A_EOI  = AW'('h130);

  logic [NSRC-1:0] mask, edge_lat, src_q, mode_edge, pend, active, rise;
  logic [PW-1:0]   prio    [NSRC];
  logic [DW-1:0]   vec     [NSRC];
  logic [IW-1:0]   stk_src [DEPTH];
  logic [PW-1:0]   stk_pri [DEPTH];
  logic [SW-1:0]   sp;
  logic [KW-1:0]   top;
  logic            found, preempt, take, eoi;
  logic [IW-1:0]   best_idx;
  logic [PW-1:0]   best_pri, top_pri;
  logic [DW-1:0]   status;

  assign rise = src & ~src_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_pend
    assign pend[i] = mode_edge[i] ? edge_lat[i] : src[i];
  end
  assign active = pend & mask;

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_pri = '0;
    for (int i = 0; i < NSRC; i++)
      if (active[i] && (!found || prio[i] > best_pri)) begin
        found    = 1'b1;
        best_idx = IW'(i);
        best_pri = prio[i];
      end
  end

  assign top     = KW'(sp - SW'(1));
  assign top_pri = (sp != '0) ? stk_pri[top] : '0;
  assign status  = (sp != '0) ? DW'(stk_src[top]) : '0;
  assign preempt = found && (sp == '0 || best_pri > top_pri) && (sp != SW'(DEPTH));
  assign irq     = preempt;
  assign take    = rd_en && addr == A_ACK && preempt;
  assign eoi     = wr_en && addr == A_EOI && sp != '0;

  always_comb begin
    rdata = '0;
    case (addr)
      A_ACK:   rdata = preempt ? vec[best_idx] : SPUR;
      A_STAT:  rdata = status;
      A_PEND:  rdata = DW'(pend);
      A_MASK:  rdata = DW'(mask);
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= '0;
      edge_lat  <= '0;
      src_q     <= '0;
      mode_edge <= '0;
      sp        <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio[i] <= '0;
        vec[i]  <= '0;
      end
      for (int k = 0; k < DEPTH; k++) begin
        stk_src[k] <= '0;
        stk_pri[k] <= '0;
      end
    end else begin
      src_q <= src;
      if (wr_en && addr == A_ESET) mask <= mask | wdata[NSRC-1:0];
      if (wr_en && addr == A_ECLR) mask <= mask & ~wdata[NSRC-1:0];
      begin
        logic [NSRC-1:0] drop;
        drop = (wr_en && addr == A_XCLR) ? wdata[NSRC-1:0] : '0;
        if (take) drop[best_idx] = 1'b1;
        edge_lat <= (edge_lat & ~drop) | rise;
      end
      if (wr_en && addr[AW-1:7] == '0) begin
        mode_edge[addr[IW+1:2]] <= wdata[5];
        prio[addr[IW+1:2]]      <= wdata[PW-1:0];
      end
      if (wr_en && addr[AW-1:7] == (AW-7)'(1)) vec[addr[IW+1:2]] <= wdata;
      if (take) begin
        stk_src[KW'(sp)] <= best_idx;
        stk_pri[KW'(sp)] <= best_pri;
        sp <= sp + SW'(1);
      end else if (eoi) begin
        sp <= sp - SW'(1);
      end
    end
  end

  a_r2_set_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ESET) |=> ((mask & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));
  a_r2_clr_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ECLR) |=> ((mask & $past(wdata[NSRC-1:0])) == '0));
  a_r4_edge_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_XCLR) |=> ((edge_lat & $past(wdata[NSRC-1:0]) & ~$past(rise)) == '0));
  a_r5_irq_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend & mask) != '0));
  a_r7_status_is_winner: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (status == DW'($past(best_idx))));
  a_r8_ack_clears_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode_edge[best_idx] && !rise[best_idx]) |=> !edge_lat[$past(best_idx)]);
  a_r9_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sp != '0) |-> (best_pri > stk_pri[top]));
  a_r10_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> (sp == $past(sp) - SW'(1)));
  a_r11_spurious_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_ACK && !irq && !wr_en) |=> $stable(sp));
endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, irq;
  logic [31:0] src = 0, wdata = 0, rdata;
  logic [11:0] addr = 0;
  int total = 0, bad = 0;

  vec_irq_ctrl i_vec_irq_ctrl (.clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  // op: 0 write, 1 read+check, 2 set src, 3 check irq; {op, addr, data, req}
  localparam int N = 55;
  localparam logic [49:0] TAB [N] = '{
    {2'd0,12'h08C,32'h300,4'd7},  {2'd0,12'h094,32'h500,4'd7},  {2'd0,12'h0A4,32'h900,4'd7},
    {2'd0,12'h014,32'h22,4'd3},   {2'd0,12'h00C,32'h01,4'd3},   {2'd0,12'h024,32'h05,4'd3},
    {2'd2,12'h000,32'h8,4'd3},    {2'd1,12'h108,32'h8,4'd3},    // R3 level follows input
    {2'd3,12'h000,32'h0,4'd5},    // R5 masked
    {2'd0,12'h120,32'h8,4'd2},    {2'd0,12'h120,32'h0,4'd2},    {2'd1,12'h10C,32'h8,4'd2}, // R2
    {2'd3,12'h000,32'h1,4'd5},
    {2'd2,12'h000,32'h28,4'd3},   {2'd1,12'h108,32'h28,4'd3},   // R3 edge latched
    {2'd0,12'h120,32'h20,4'd2},
    {2'd1,12'h100,32'h500,4'd6},  // R6 prio 2 beats prio 1
    {2'd1,12'h104,32'h5,4'd7},    // R7
    {2'd1,12'h108,32'h8,4'd8},    // R8 edge auto-cleared
    {2'd3,12'h000,32'h0,4'd9},    // R9 lower held off
    {2'd2,12'h000,32'h228,4'd9},  {2'd0,12'h120,32'h200,4'd9},  {2'd3,12'h000,32'h1,4'd9},
    {2'd1,12'h100,32'h900,4'd7},  {2'd1,12'h104,32'h9,4'd7},
    {2'd0,12'h130,32'h0,4'd10},   {2'd1,12'h104,32'h5,4'd10},   // R10 pop to outer
    {2'd2,12'h000,32'h28,4'd10},  {2'd3,12'h000,32'h0,4'd9},
    {2'd0,12'h130,32'h0,4'd10},   {2'd1,12'h104,32'h0,4'd10},
    {2'd0,12'h130,32'h0,4'd10},   {2'd1,12'h104,32'h0,4'd10},   // R10 empty EOI
    {2'd3,12'h000,32'h1,4'd5},
    {2'd0,12'h124,32'h8,4'd2},    {2'd1,12'h10C,32'h220,4'd2},  {2'd3,12'h000,32'h0,4'd5},
    {2'd1,12'h100,32'hFFFFFFFF,4'd11}, {2'd1,12'h104,32'h0,4'd11}, // R11
    {2'd2,12'h000,32'h0,4'd4},    {2'd2,12'h000,32'h20,4'd4},   {2'd1,12'h108,32'h20,4'd4},
    {2'd0,12'h128,32'h20,4'd4},   {2'd1,12'h108,32'h0,4'd4},    // R4
    {2'd0,12'h030,32'h3,4'd6},    {2'd0,12'h038,32'h3,4'd6},    {2'd0,12'h0B0,32'hC00,4'd6},
    {2'd0,12'h0B8,32'hE00,4'd6},  {2'd0,12'h120,32'h5000,4'd6}, {2'd2,12'h000,32'h5000,4'd6},
    {2'd1,12'h100,32'hC00,4'd6},  // R6 tie: lower number
    {2'd3,12'h000,32'h0,4'd9},    // R9 equal prio held off
    {2'd1,12'h104,32'hC,4'd7},    {2'd0,12'h130,32'h0,4'd10},   {2'd3,12'h000,32'h1,4'd10}
  };

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); addr = a; rd_en = 1; wr_en = 0;
    #5 chk(rdata, exp, req);
    @(negedge clk); rd_en = 0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5 chk({31'd0, irq}, 0, "R1 irq");
    rd(12'h10C, 0, "R1 mask");
    rd(12'h108, 0, "R1 pend");
    rd(12'h104, 0, "R1 status");
    for (int i = 0; i < N; i++) begin
      logic [1:0] op; logic [11:0] a; logic [31:0] d; string req;
      {op, a, d} = TAB[i][49:4];
      req = $sformatf("R%0d step %0d", TAB[i][3:0], i);
      @(negedge clk);
      wr_en = 0; rd_en = 0;
      case (op)
        2'd0: begin addr = a; wdata = d; wr_en = 1; end
        2'd1: begin addr = a; rd_en = 1; #5 chk(rdata, d, req); end
        2'd2: src = d;
        default: begin #5 chk({31'd0, irq}, d, req); end
      endcase
    end
    @(negedge clk); wr_en = 0; rd_en = 0;
    // R1: reset mid-run returns everything to idle
    src = 0; rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    #5 chk({31'd0, irq}, 0, "R1 irq after reset");
    rd(12'h10C, 0, "R1 mask after reset");
    rd(12'h104, 0, "R1 status after reset");
    rd(12'h100, 32'hFFFFFFFF, "R11 ack after reset");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule